// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block takes a single-rank DDR2 device from power-on to a state where normal traffic may begin. After a start pulse it waits out the power-up interval and a short settle interval. It then issues a fixed series of twelve commands on a simple command port, which carries an opcode, a bank, a row/mode address and a valid/ready handshake. It raises done once the series and all its spacing have completed.

The four mode-register images are inputs to the block. The sequencer only alters the bits that the sequence itself owns: the DLL-reset bit of the main mode register, and the DLL-disable and OCD-control bits of the first extended register. Every wait is a load-time input counted in controller clocks, so one netlist serves any speed grade. The waits are power-up, settle, precharge, refresh, mode-set spacing and DLL lock.

Top module: `ddr2_init_seq`

## Requirements
- R1: While reset is asserted and until a start is seen, `cmd_valid_o`, `busy_o` and `done_o` are all low.
- R2: `start_i` sampled high in the idle state launches the series, and `busy_o` is high from the next cycle until done. A start seen while busy or after done changes nothing at the outputs.
- R3: After the start edge, `cmd_valid_o` stays low for max(`t_pwrup_i`,1) cycles and then for max(`t_settle_i`,1) more cycles. The first command is presented in the cycle that follows.
- R4: Exactly twelve commands are accepted per run. The opcode encoding is 0 deselect, 1 precharge-all, 2 refresh, 3 mode-register set. The commands come in this order: deselect; precharge-all; set EMR2; set EMR3; set EMR with DLL on; set MR with DLL reset; precharge-all; refresh; refresh; set MR without DLL reset; set EMR with OCD default; set EMR with OCD exit. Precharge-all drives address bit 10 high and all other address bits low. Deselect and refresh drive address 0, and all non-mode commands drive bank 0.
- R5: A mode-register set chooses its target by bank: MR on bank 0, EMR on bank 1, EMR2 on bank 2, EMR3 on bank 3. EMR2 and EMR3 carry `emr2_i` and `emr3_i` unchanged.
- R6: The first MR write carries `mr_i` with bit 8 (DLL reset) forced to 1. The second carries `mr_i` with bit 8 forced to 0. All other bits come from `mr_i`.
- R7: The DLL-on EMR write and the OCD-exit write carry `emr_i` with bit 0 and bits 9:7 cleared. The OCD-default write carries the same value with bits 9:7 set to 111.
- R8: After each accepted command, `cmd_valid_o` is low for exactly max(W,1) cycles. W is `t_mrd_i` after deselect and mode sets, `t_rp_i`+1 after precharge-all (8-bank device), and `t_rfc_i` after refresh.
- R9: A presented command keeps `cmd_valid_o` high, with opcode, bank and address unchanged, until `cmd_ready_i` is sampled high.
- R10: `done_o` does not rise before `t_dllk_i`+1 clock edges have passed since the edge that accepted the DLL-reset MR write. If the series ends earlier, done waits for that count.
- R11: `done_o` rises one cycle after the last wait expires, provided R10 is met. It then stays high with `busy_o` and `cmd_valid_o` low until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch the series when idle |
| mr_i | input | ADDR_W | Main mode-register image |
| emr_i | input | ADDR_W | First extended mode-register image |
| emr2_i | input | ADDR_W | Second extended mode-register image |
| emr3_i | input | ADDR_W | Third extended mode-register image |
| t_pwrup_i | input | PWR_W | Power-up wait in clocks |
| t_settle_i | input | TW | Settle wait after power-up, in clocks |
| t_rp_i | input | TW | Precharge wait in clocks |
| t_rfc_i | input | TW | Refresh wait in clocks |
| t_mrd_i | input | TW | Mode-set spacing in clocks |
| t_dllk_i | input | TW | DLL lock time in clocks |
| cmd_ready_i | input | 1 | Command port accepts the presented command |
| cmd_valid_o | output | 1 | A command is presented |
| cmd_op_o | output | 2 | Command opcode |
| cmd_bank_o | output | BANK_W | Bank / mode-register select |
| cmd_addr_o | output | ADDR_W | Address / mode-register value |
| busy_o | output | 1 | Series in progress |
| done_o | output | 1 | Series complete, sticky until reset |

## Verification
A wrong step index or state shows up at the very next presented command. The opcode, the bank or the mode value differs from the expected entry, or a twelfth acceptance is missing or extra. A timer that loads or counts wrongly moves the rising edge of `cmd_valid_o` by at least one cycle, and the bench catches this in the first gap it affects. The reference model runs in parallel and is compared on every clock, so any divergence in valid, fields, busy or done is reported in the cycle it appears. A lock counter that is not honoured shows as `done_o` rising early in runs where the lock time outlasts the tail of the series.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  localparam int NUM_STEPS = 12;
  localparam int STEP_W    = $clog2(NUM_STEPS);
  localparam logic [STEP_W-1:0] STEP_MR_DLLRST = STEP_W'(5);

  typedef enum logic [1:0] {
    OP_DESEL = 2'd0,
    OP_PREA  = 2'd1,
    OP_REF   = 2'd2,
    OP_MRS   = 2'd3
  } cmd_op_e;

  typedef enum logic [2:0] {
    SRC_ZERO,
    SRC_AUTO_PRE,
    SRC_MR_RST,
    SRC_MR_RUN,
    SRC_EMR_ON,
    SRC_EMR_OCD,
    SRC_EMR2,
    SRC_EMR3
  } addr_src_e;

  typedef enum logic [1:0] {
    WK_MRD,
    WK_PREA,
    WK_RFC
  } wait_kind_e;

  typedef struct packed {
    cmd_op_e    op;
    logic [1:0] msel;
    addr_src_e  src;
    wait_kind_e wk;
  } step_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PWRUP,
    ST_SETTLE,
    ST_ISSUE,
    ST_GAP,
    ST_LOCK,
    ST_DONE
  } seq_state_e;

  // order is the behaviour: the device requires exactly this series
  function automatic step_t step_lookup(input logic [STEP_W-1:0] idx);
    step_t s;
    case (idx)
      4'd0:    s = step_t'{OP_DESEL, 2'd0, SRC_ZERO,     WK_MRD};
      4'd1:    s = step_t'{OP_PREA,  2'd0, SRC_AUTO_PRE, WK_PREA};
      4'd2:    s = step_t'{OP_MRS,   2'd2, SRC_EMR2,     WK_MRD};
      4'd3:    s = step_t'{OP_MRS,   2'd3, SRC_EMR3,     WK_MRD};
      4'd4:    s = step_t'{OP_MRS,   2'd1, SRC_EMR_ON,   WK_MRD};
      4'd5:    s = step_t'{OP_MRS,   2'd0, SRC_MR_RST,   WK_MRD};
      4'd6:    s = step_t'{OP_PREA,  2'd0, SRC_AUTO_PRE, WK_PREA};
      4'd7:    s = step_t'{OP_REF,   2'd0, SRC_ZERO,     WK_RFC};
      4'd8:    s = step_t'{OP_REF,   2'd0, SRC_ZERO,     WK_RFC};
      4'd9:    s = step_t'{OP_MRS,   2'd0, SRC_MR_RUN,   WK_MRD};
      4'd10:   s = step_t'{OP_MRS,   2'd1, SRC_EMR_OCD,  WK_MRD};
      4'd11:   s = step_t'{OP_MRS,   2'd1, SRC_EMR_ON,   WK_MRD};
      default: s = step_t'{OP_DESEL, 2'd0, SRC_ZERO,     WK_MRD};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/ddr2_cycle_timer.sv
module ddr2_cycle_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         last_o,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
  assign last_o = (cnt_q <= W'(1));

endmodule

// File: rtl/ddr2_cmd_gen.sv
module ddr2_cmd_gen
  import ddr2_init_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int BANK_W    = 3,
  parameter int TW        = 8,
  parameter int NUM_BANKS = 8
) (
  input  logic [STEP_W-1:0] step_i,
  input  logic [ADDR_W-1:0] mr_i,
  input  logic [ADDR_W-1:0] emr_i,
  input  logic [ADDR_W-1:0] emr2_i,
  input  logic [ADDR_W-1:0] emr3_i,
  input  logic [TW-1:0]     t_rp_i,
  input  logic [TW-1:0]     t_rfc_i,
  input  logic [TW-1:0]     t_mrd_i,
  output logic [1:0]        op_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [TW:0]       wait_o
);

  localparam int WW          = TW + 1;
  localparam int AP_BIT      = 10;
  localparam int DLL_RST_BIT = 8;
  localparam int OCD_LO      = 7;
  localparam int DLL_OFF_BIT = 0;
  localparam logic [ADDR_W-1:0] AP_MASK      = ADDR_W'(1) << AP_BIT;
  localparam logic [ADDR_W-1:0] DLL_RST_MASK = ADDR_W'(1) << DLL_RST_BIT;
  localparam logic [ADDR_W-1:0] OCD_MASK     = ADDR_W'(7) << OCD_LO;
  localparam logic [ADDR_W-1:0] DLL_OFF_MASK = ADDR_W'(1) << DLL_OFF_BIT;
  // all-bank precharge on an 8-bank part needs one extra clock
  localparam logic [WW-1:0] PREA_EXTRA = (NUM_BANKS == 8) ? WW'(1) : '0;

  step_t s;
  logic [ADDR_W-1:0] emr_base;

  assign s        = step_lookup(step_i);
  assign emr_base = emr_i & ~(OCD_MASK | DLL_OFF_MASK);
  assign op_o     = s.op;
  assign bank_o   = BANK_W'(s.msel);

  always_comb begin
    unique case (s.src)
      SRC_ZERO:     addr_o = '0;
      SRC_AUTO_PRE: addr_o = AP_MASK;
      SRC_MR_RST:   addr_o = mr_i | DLL_RST_MASK;
      SRC_MR_RUN:   addr_o = mr_i & ~DLL_RST_MASK;
      SRC_EMR_ON:   addr_o = emr_base;
      SRC_EMR_OCD:  addr_o = emr_base | OCD_MASK;
      SRC_EMR2:     addr_o = emr2_i;
      SRC_EMR3:     addr_o = emr3_i;
      default:      addr_o = '0;
    endcase
  end

  always_comb begin
    unique case (s.wk)
      WK_PREA: wait_o = WW'(t_rp_i) + PREA_EXTRA;
      WK_RFC:  wait_o = WW'(t_rfc_i);
      default: wait_o = WW'(t_mrd_i);
    endcase
  end

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int BANK_W    = 3,
  parameter int TW        = 8,
  parameter int PWR_W     = 18,
  parameter int NUM_BANKS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] mr_i,
  input  logic [ADDR_W-1:0] emr_i,
  input  logic [ADDR_W-1:0] emr2_i,
  input  logic [ADDR_W-1:0] emr3_i,
  input  logic [PWR_W-1:0]  t_pwrup_i,
  input  logic [TW-1:0]     t_settle_i,
  input  logic [TW-1:0]     t_rp_i,
  input  logic [TW-1:0]     t_rfc_i,
  input  logic [TW-1:0]     t_mrd_i,
  input  logic [TW-1:0]     t_dllk_i,
  input  logic              cmd_ready_i,
  output logic              cmd_valid_o,
  output logic [1:0]        cmd_op_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam int CNT_W = (PWR_W > TW + 1) ? PWR_W : TW + 1;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q;
  logic              step_inc;
  logic              tmr_load, tmr_last, tmr_zero_unused;
  logic [CNT_W-1:0]  tmr_val;
  logic              dll_load, dll_zero, dll_last_unused, dll_armed_q, dll_ok;
  logic              accept, step_last;
  logic [1:0]        gen_op;
  logic [BANK_W-1:0] gen_bank;
  logic [ADDR_W-1:0] gen_addr;
  logic [TW:0]       gap_len;

  ddr2_cmd_gen #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .TW(TW), .NUM_BANKS(NUM_BANKS)
  ) u_gen (
    .step_i (step_q),
    .mr_i   (mr_i),
    .emr_i  (emr_i),
    .emr2_i (emr2_i),
    .emr3_i (emr3_i),
    .t_rp_i (t_rp_i),
    .t_rfc_i(t_rfc_i),
    .t_mrd_i(t_mrd_i),
    .op_o   (gen_op),
    .bank_o (gen_bank),
    .addr_o (gen_addr),
    .wait_o (gap_len)
  );

  // shared gap timer: power-up, settle and inter-command waits
  ddr2_cycle_timer #(.W(CNT_W)) u_gap_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .last_o    (tmr_last),
    .zero_o    (tmr_zero_unused)
  );

  // DLL lock runs beside the series, started by the DLL-reset write
  ddr2_cycle_timer #(.W(TW)) u_dll_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (dll_load),
    .load_val_i(t_dllk_i),
    .last_o    (dll_last_unused),
    .zero_o    (dll_zero)
  );

  assign accept    = (state_q == ST_ISSUE) && cmd_ready_i;
  assign step_last = (step_q == LAST_STEP);
  assign dll_load  = accept && (step_q == STEP_MR_DLLRST);
  assign dll_ok    = dll_armed_q && dll_zero;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    step_inc = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d  = ST_PWRUP;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(t_pwrup_i);
      end
      ST_PWRUP: if (tmr_last) begin
        state_d  = ST_SETTLE;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(t_settle_i);
      end
      ST_SETTLE: if (tmr_last) state_d = ST_ISSUE;
      ST_ISSUE: if (cmd_ready_i) begin
        state_d  = ST_GAP;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(gap_len);
      end
      ST_GAP: if (tmr_last) begin
        if (!step_last) begin
          state_d  = ST_ISSUE;
          step_inc = 1'b1;
        end else if (dll_ok) begin
          state_d = ST_DONE;
        end else begin
          state_d = ST_LOCK;
        end
      end
      ST_LOCK: if (dll_ok) state_d = ST_DONE;
      ST_DONE: state_d = ST_DONE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      step_q      <= '0;
      dll_armed_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (step_inc) step_q <= step_q + 1'b1;
      if (dll_load) dll_armed_q <= 1'b1;
    end
  end

  assign cmd_valid_o = (state_q == ST_ISSUE);
  assign cmd_op_o    = cmd_valid_o ? gen_op   : '0;
  assign cmd_bank_o  = cmd_valid_o ? gen_bank : '0;
  assign cmd_addr_o  = cmd_valid_o ? gen_addr : '0;
  assign busy_o      = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done_o      = (state_q == ST_DONE);

  assert_start_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> busy_o || done_o);

  assert_gap_after_accept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_ready_i |=> !cmd_valid_o);

  assert_hold_until_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_op_o)
      && $stable(cmd_bank_o) && $stable(cmd_addr_o));

  assert_dll_locked_at_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> dll_ok);

  assert_done_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o && !cmd_valid_o);

endmodule

// File: tb/sim_ddr2_init_seq.sv
`timescale 1ns/1ps
module sim_ddr2_init_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [12:0] mr = '0, emr = '0, emr2 = '0, emr3 = '0;
  logic [17:0] t_pwrup = '0;
  logic [7:0]  t_settle = '0, t_rp = '0, t_rfc = '0, t_mrd = '0, t_dllk = '0;
  logic        ready = 1'b1;
  logic        cmd_valid, busy, done;
  logic [1:0]  cmd_op;
  logic [2:0]  cmd_bank;
  logic [12:0] cmd_addr;

  int n_chk = 0, n_fail = 0;
  int stall_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  int acc = 0;

  // reference model state
  int m_phase = 0, m_rem = 0, m_step = 0, m_dll = 0;
  bit m_armed = 0, m_dok;

  always #4 clk = ~clk;

  ddr2_init_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .mr_i(mr), .emr_i(emr), .emr2_i(emr2), .emr3_i(emr3),
    .t_pwrup_i(t_pwrup), .t_settle_i(t_settle), .t_rp_i(t_rp),
    .t_rfc_i(t_rfc), .t_mrd_i(t_mrd), .t_dllk_i(t_dllk),
    .cmd_ready_i(ready), .cmd_valid_o(cmd_valid), .cmd_op_o(cmd_op),
    .cmd_bank_o(cmd_bank), .cmd_addr_o(cmd_addr),
    .busy_o(busy), .done_o(done)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s at %0t: actual %0h expected %0h", req, what, $time, act, exp);
    end
  endtask

  function automatic int mx(input int w);
    return (w < 1) ? 1 : w;
  endfunction

  function automatic int exp_wait(input int s);
    if (s == 1 || s == 6) return int'(t_rp) + 1;
    if (s == 7 || s == 8) return int'(t_rfc);
    return int'(t_mrd);
  endfunction

  function automatic int exp_op(input int s);
    case (s)
      0: return 0;
      1, 6: return 1;
      7, 8: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic int exp_bank(input int s);
    case (s)
      2: return 2;
      3: return 3;
      4, 10, 11: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_addr(input int s);
    int e;
    e = int'(emr) & ~32'h381;
    case (s)
      1, 6: return 32'h400;
      2: return int'(emr2);
      3: return int'(emr3);
      4, 11: return e;
      5: return int'(mr) | 32'h100;
      9: return int'(mr) & ~32'h100;
      10: return e | 32'h380;
      default: return 0;
    endcase
  endfunction

  function automatic string field_req(input int s);
    case (s)
      2, 3: return "R5";
      5, 9: return "R6";
      4, 10, 11: return "R7";
      default: return "R4";
    endcase
  endfunction

  // behavioural reference: phase 0 idle,1 power-up,2 settle,3 issue,4 gap,5 lock,6 done
  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_rem = 0; m_step = 0; m_dll = 0; m_armed = 0;
    end else begin
      m_dok = m_armed && (m_dll == 0);
      if (m_dll > 0) m_dll--;
      case (m_phase)
        0: if (start) begin m_phase = 1; m_rem = mx(int'(t_pwrup)); end
        1: if (m_rem <= 1) begin m_phase = 2; m_rem = mx(int'(t_settle)); end else m_rem--;
        2: if (m_rem <= 1) m_phase = 3; else m_rem--;
        3: if (ready) begin
             if (m_step == 5) begin m_dll = int'(t_dllk); m_armed = 1; end
             m_phase = 4; m_rem = mx(exp_wait(m_step));
           end
        4: if (m_rem <= 1) begin
             if (m_step < 11) begin m_step++; m_phase = 3; end
             else m_phase = m_dok ? 6 : 5;
           end else m_rem--;
        5: if (m_dok) m_phase = 6;
        default: ;
      endcase
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      string vreq;
      case (m_phase)
        1, 2: vreq = "R3";
        3: vreq = "R9";
        4: vreq = "R8";
        5: vreq = "R10";
        6: vreq = "R11";
        default: vreq = "R2";
      endcase
      chk(vreq, "cmd_valid", int'(cmd_valid), int'(m_phase == 3));
      if (m_phase == 3 && cmd_valid) begin
        chk(field_req(m_step), "cmd_op", int'(cmd_op), exp_op(m_step));
        chk(field_req(m_step), "cmd_bank", int'(cmd_bank), exp_bank(m_step));
        chk(field_req(m_step), "cmd_addr", int'(cmd_addr), exp_addr(m_step));
      end
      chk("R2", "busy", int'(busy), int'(m_phase >= 1 && m_phase <= 5));
      chk((m_phase == 5) ? "R10" : "R11", "done", int'(done), int'(m_phase == 6));
      if (cmd_valid && ready) acc++;
    end
  end

  initial begin
    forever begin
      @(posedge clk); #2;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (stall_mode)
        0: ready = 1'b1;
        1: ready = lfsr[0] | lfsr[5];
        default: ready = (lfsr[3:0] == 4'd0);
      endcase
    end
  end

  task automatic run(input int tp, input int ts, input int trp, input int trfc,
                     input int tmrd, input int tdl, input int stall, input bit pester,
                     input int vmr, input int vemr, input int vemr2, input int vemr3);
    int cyc;
    @(posedge clk); #2;
    rst_n = 1'b0; start = 1'b0;
    t_pwrup = 18'(tp); t_settle = 8'(ts); t_rp = 8'(trp); t_rfc = 8'(trfc);
    t_mrd = 8'(tmrd); t_dllk = 8'(tdl); stall_mode = stall;
    mr = 13'(vmr); emr = 13'(vemr); emr2 = 13'(vemr2); emr3 = 13'(vemr3);
    @(negedge clk);
    chk("R1", "valid in reset", int'(cmd_valid), 0);
    chk("R1", "busy in reset", int'(busy), 0);
    chk("R1", "done in reset", int'(done), 0);
    @(posedge clk); #2; rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "valid idle", int'(cmd_valid), 0);
    chk("R1", "done idle", int'(done), 0);
    acc = 0;
    @(posedge clk); #2; start = 1'b1;
    @(posedge clk); #2; start = 1'b0;
    cyc = 0;
    while (m_phase != 6 && cyc < 20000) begin
      @(posedge clk); #2;
      start = pester && (cyc % 29 == 0);
      cyc++;
    end
    start = 1'b0;
    @(negedge clk);
    chk("R4", "accepted command count", acc, 12);
    chk("R11", "done reached", int'(done), 1);
    // starts after done must be ignored
    repeat (12) begin @(posedge clk); #2; start = ~start; end
    start = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R2", "accepts after done", acc, 12);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    // nominal timings, lock outlasts the tail of the series
    run(40, 3, 6, 78, 2, 200, 0, 1'b0, 32'h0A63, 32'h0004, 32'h0000, 32'h0000);
    // all-zero loads, random stalls, restless start
    run(0, 0, 0, 0, 0, 0, 1, 1'b1, 32'h1FFF, 32'h1FFF, 32'h0AAA, 32'h0555);
    // long power-up, short lock, sparse ready
    run(300, 1, 3, 10, 1, 3, 2, 1'b1, 32'h0A62, 32'h0441, 32'h0080, 32'h0001);
    // maximum loads, precharge wait wider than its input
    run(1, 0, 255, 255, 255, 255, 0, 1'b1, 32'h0B63, 32'h0386, 32'h1000, 32'h0F0F);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule